// File: doc/BRIEF.md
# Serial Data Lane Byte Adapter

This block joins one pair of unidirectional high-speed serial data lines to four byte-wide memory devices on a module. It runs entirely on the fast bit clock. A slow-cycle enable pulses once per memory cycle. On that pulse the read side copies one byte from each device into its holding registers. It then sends the four bytes as a single 32-bit serial packet, with a start strobe on the first bit. The write side works the other way. It gathers 32 serial bits that begin with a receive start strobe, then presents one byte to each device in the same cycle, together with a one-cycle valid pulse.

A packet is 32 bit times long, which is exactly one memory cycle. The serial rate therefore equals the combined parallel rate of the four devices, and transmit packets can follow each other with no idle bit between them. The two directions are independent and may be busy at the same time. If a capture enable arrives while a packet is still being sent, it is refused and an overrun flag is raised.

Top module: `lane_serdes_adapter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tx_bit`, `tx_start`, `tx_overrun` and `wr_valid` are 0 and `wr_lane_data` is all zeros.
- R2: When `cyc_en` is sampled high while no packet is being sent, all four lanes of `rd_lane_data` are captured at that clock edge. The first packet bit appears in the following cycle, and `tx_start` is high only during that first bit.
- R3: A transmitted packet is 32 bits, most significant first. Lane 0 (`rd_lane_data[7:0]`) fills packet bits 31:24 and goes first, and lane 3 (`rd_lane_data[31:24]`) fills bits 7:0 and goes last. Within each byte, bit 7 is sent first.
- R4: Changes on `rd_lane_data` after the capture edge do not change the packet being sent.
- R5: A `cyc_en` sampled during the 32nd bit of a packet is accepted. The next packet then starts in the very next cycle, so back-to-back packets have their `tx_start` strobes exactly 32 cycles apart.
- R6: A `cyc_en` sampled during bits 1 to 31 of a packet is refused. `tx_overrun` is high for one cycle in the cycle after that edge. The packet in flight finishes unchanged, and no new packet starts after it.
- R7: When no packet is being sent, `tx_bit` and `tx_start` are held at 0.
- R8: `rx_start` high marks the first of 32 bits on `rx_bit`, received most significant first. In the cycle after the 32nd bit, `wr_valid` is high for exactly one cycle and `wr_lane_data` holds all four bytes. The first eight received bits go to lane 0 (`wr_lane_data[7:0]`) and the last eight go to lane 3 (`wr_lane_data[31:24]`).
- R9: `wr_lane_data` keeps its value until the next valid pulse. Bits that arrive after a complete packet without a new `rx_start` are ignored.
- R10: An `rx_start` that arrives before 32 bits have been received drops the partial packet and starts a new one with that bit.
- R11: Transmission and reception run independently and at the same time, with neither one disturbing the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Slow-cycle enable; requests a capture of the read lanes |
| rd_lane_data | input | 32 | Read bytes from the devices; lane g at bits 8g+7:8g |
| tx_bit | output | 1 | Serial transmit data |
| tx_start | output | 1 | High with the first bit of each transmit packet |
| tx_overrun | output | 1 | One-cycle pulse when a capture request is refused |
| rx_bit | input | 1 | Serial receive data |
| rx_start | input | 1 | High with the first bit of each receive packet |
| wr_lane_data | output | 32 | Write bytes to the devices; lane g at bits 8g+7:8g |
| wr_valid | output | 1 | One-cycle pulse when `wr_lane_data` is updated |

## Verification
A receive packet can complete in the same cycle that a transmit capture is accepted or refused, or in the same cycle as a transmit start strobe. To provoke this, the transmit stream and the receive stream are driven by two concurrent processes with different periods: back-to-back transmit packets repeat every 32 cycles, and receive packets repeat every 35 cycles, with aborted partial packets mixed in. Because of this, the receive valid pulse drifts through every bit position of the transmit packet. Every transmitted bit and strobe is compared with the packet computed from the lanes that were driven, and every write-side update is compared with the bytes that were sent. A clash between the two directions therefore shows up as a bit or byte mismatch.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int unsigned LSA_LANES  = 4;
    localparam int unsigned LSA_LANE_W = 8;

    typedef enum logic {
        SER_IDLE,
        SER_SHIFT
    } ser_state_e;

    typedef enum logic {
        DES_HUNT,
        DES_FILL
    } des_state_e;

    // one bit time on a serial line: framing strobe plus data
    typedef struct packed {
        logic strobe;
        logic data;
    } ser_sym_t;

    // packet bit offset of a lane's byte; lane 0 sits in the top byte
    function automatic int unsigned lane_slot(int unsigned lane,
                                              int unsigned lanes,
                                              int unsigned lane_w);
        return (lanes - 1 - lane) * lane_w;
    endfunction

    // a capture request that lands mid-packet (not on its final bit)
    function automatic logic capture_refused(logic en, ser_state_e st, logic last);
        return en && (st == SER_SHIFT) && !last;
    endfunction

endpackage

// File: rtl/lsa_tx_serializer.sv
module lsa_tx_serializer
    import lsa_pkg::*;
#(
    parameter int unsigned LANES  = LSA_LANES,
    parameter int unsigned LANE_W = LSA_LANE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cyc_en,
    input  logic [LANES*LANE_W-1:0]   rd_lanes,
    output ser_sym_t                  tx_sym,
    output logic                      overrun
);
    localparam int unsigned PKT_W = LANES * LANE_W;
    localparam int unsigned CW    = $clog2(PKT_W);
    localparam int unsigned BW    = $clog2(LANE_W);

    logic [LANES-1:0][LANE_W-1:0] hold;
    ser_state_e                   state;
    logic [CW-1:0]                pos;
    logic                         last;
    logic                         accept;
    logic [CW-BW-1:0]             lane_idx;
    logic [BW-1:0]                bit_idx;

    assign last   = (pos == CW'(PKT_W - 1));
    assign accept = cyc_en && ((state == SER_IDLE) || last);

    // holding registers: one byte per device, loaded only on an accepted capture
    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (accept) begin
            for (int g = 0; g < LANES; g++) begin
                hold[g] <= rd_lanes[g*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SER_IDLE;
            pos     <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= capture_refused(cyc_en, state, last);
            if (accept) begin
                state <= SER_SHIFT;
                pos   <= '0;
            end else if (state == SER_SHIFT) begin
                if (last) begin
                    state <= SER_IDLE;
                    pos   <= '0;
                end else begin
                    pos <= pos + CW'(1);
                end
            end
        end
    end

    // upper position bits walk the lanes in order, lower bits walk each byte MSB first
    assign lane_idx = pos[CW-1:BW];
    assign bit_idx  = ~pos[BW-1:0];

    always_comb begin
        tx_sym.data   = 1'b0;
        tx_sym.strobe = 1'b0;
        if (state == SER_SHIFT) begin
            tx_sym.data   = hold[lane_idx][bit_idx];
            tx_sym.strobe = (pos == '0);
        end
    end

endmodule

// File: rtl/lsa_rx_deserializer.sv
module lsa_rx_deserializer
    import lsa_pkg::*;
#(
    parameter int unsigned LANES  = LSA_LANES,
    parameter int unsigned LANE_W = LSA_LANE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  ser_sym_t                  rx_sym,
    output logic [LANES*LANE_W-1:0]   wr_lanes,
    output logic                      wr_valid
);
    localparam int unsigned PKT_W = LANES * LANE_W;
    localparam int unsigned CW    = $clog2(PKT_W);

    logic [PKT_W-1:0] sh;
    logic [PKT_W-1:0] nxt;
    logic [PKT_W-1:0] pkt_q;
    des_state_e       st;
    logic [CW-1:0]    cnt;
    logic             done;

    assign nxt  = {sh[PKT_W-2:0], rx_sym.data};
    assign done = (st == DES_FILL) && !rx_sym.strobe && (cnt == CW'(PKT_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            st       <= DES_HUNT;
            cnt      <= '0;
            pkt_q    <= '0;
            wr_valid <= 1'b0;
        end else begin
            wr_valid <= done;
            if (done) begin
                pkt_q <= nxt;
            end
            if (rx_sym.strobe) begin
                // a strobe always opens a fresh packet, dropping any partial one
                sh  <= nxt;
                st  <= DES_FILL;
                cnt <= CW'(1);
            end else if (st == DES_FILL) begin
                sh <= nxt;
                if (cnt == CW'(PKT_W - 1)) begin
                    st  <= DES_HUNT;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // spread the packet over the device lanes: first received byte to lane 0
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned SLOT = lane_slot(g, LANES, LANE_W);
        assign wr_lanes[g*LANE_W +: LANE_W] = pkt_q[SLOT +: LANE_W];
    end

endmodule

// File: rtl/lane_serdes_adapter.sv
module lane_serdes_adapter
    import lsa_pkg::*;
#(
    parameter int unsigned LANES  = LSA_LANES,
    parameter int unsigned LANE_W = LSA_LANE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cyc_en,
    input  logic [LANES*LANE_W-1:0]   rd_lane_data,
    output logic                      tx_bit,
    output logic                      tx_start,
    output logic                      tx_overrun,
    input  logic                      rx_bit,
    input  logic                      rx_start,
    output logic [LANES*LANE_W-1:0]   wr_lane_data,
    output logic                      wr_valid
);
    ser_sym_t tx_sym;
    ser_sym_t rx_sym;

    assign rx_sym.strobe = rx_start;
    assign rx_sym.data   = rx_bit;

    lsa_tx_serializer #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cyc_en   (cyc_en),
        .rd_lanes (rd_lane_data),
        .tx_sym   (tx_sym),
        .overrun  (tx_overrun)
    );

    lsa_rx_deserializer #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_sym   (rx_sym),
        .wr_lanes (wr_lane_data),
        .wr_valid (wr_valid)
    );

    assign tx_bit   = tx_sym.data;
    assign tx_start = tx_sym.strobe;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int unsigned PKT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_en,
    input logic             tx_bit,
    input logic             tx_start,
    input logic             tx_overrun,
    input logic             rx_start,
    input logic             wr_valid,
    input logic [PKT_W-1:0] wr_lane_data
);
    logic [15:0] since_start;
    logic        seen_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_start <= '0;
            seen_start  <= 1'b0;
        end else if (tx_start) begin
            since_start <= '0;
            seen_start  <= 1'b1;
        end else if (since_start != 16'hFFFF) begin
            since_start <= since_start + 16'd1;
        end
    end

    p_start_cause_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(cyc_en));

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    p_start_spacing_r5: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (!seen_start || (since_start >= 16'(PKT_W - 1))));

    p_ovr_cause_r6: assert property (@(posedge clk) disable iff (rst)
        tx_overrun |-> ($past(cyc_en) && !tx_start));

    p_quiet_before_first_r7: assert property (@(posedge clk) disable iff (rst)
        (!seen_start && !tx_start) |-> !tx_bit);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    p_valid_source_r8: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !$past(rx_start));

    p_wr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> $stable(wr_lane_data));

endmodule

bind lane_serdes_adapter lsa_checker #(.PKT_W(LANES*LANE_W)) u_chk (.*);

// File: tb/tb_lane_serdes_adapter.sv
module tb_lane_serdes_adapter;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_en;
    logic [31:0] rd_lane_data;
    logic        tx_bit, tx_start, tx_overrun;
    logic        rx_bit, rx_start;
    logic [31:0] wr_lane_data;
    logic        wr_valid;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lane_serdes_adapter dut (
        .clk          (clk),
        .rst          (rst),
        .cyc_en       (cyc_en),
        .rd_lane_data (rd_lane_data),
        .tx_bit       (tx_bit),
        .tx_start     (tx_start),
        .tx_overrun   (tx_overrun),
        .rx_bit       (rx_bit),
        .rx_start     (rx_start),
        .wr_lane_data (wr_lane_data),
        .wr_valid     (wr_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // lane g at [8g+7:8g] -> packet with lane 0 in bits 31:24
    function automatic logic [31:0] to_pkt(input logic [31:0] lanes);
        return {lanes[7:0], lanes[15:8], lanes[23:16], lanes[31:24]};
    endfunction

    function automatic logic [31:0] tx_pat(input int k);
        if (k < 32) return 32'h1 << k;
        return 32'(k) * 32'h9E3779B1 + 32'h13579BDF;
    endfunction

    function automatic logic [31:0] rx_pat(input int k);
        if (k < 32) return ~(32'h1 << k);
        return (32'(k) * 32'h2545F491) ^ 32'hC0FFEE11;
    endfunction

    task automatic tx_kick(input logic [31:0] lanes);
        @(negedge clk);
        rd_lane_data = lanes;
        cyc_en = 1'b1;
    endtask

    // observe one packet whose capture edge has just been requested
    task automatic tx_packet(input logic [31:0] lanes, input int ovr_at,
                             input bit chain, input logic [31:0] nxt);
        logic [31:0] pkt;
        pkt = to_pkt(lanes);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk(tx_start == (i == 0), "R2 start strobe", 32'(tx_start), 32'(i == 0));
            chk(tx_bit == pkt[31-i], (i == 0) ? "R3 R11 first bit" : "R3 R4 R11 bit",
                32'(tx_bit), 32'(pkt[31-i]));
            chk(tx_overrun == (ovr_at >= 0 && i == ovr_at + 1), "R6 overrun pulse",
                32'(tx_overrun), 32'(ovr_at >= 0 && i == ovr_at + 1));
            cyc_en = 1'b0;
            if (i == 0) rd_lane_data = ~lanes;
            if (i == ovr_at) begin
                cyc_en = 1'b1;
                rd_lane_data = lanes ^ 32'hA5A5_5A5A;
            end
            if (i == 31 && chain) begin
                cyc_en = 1'b1;
                rd_lane_data = nxt;
            end
        end
    endtask

    task automatic tx_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!tx_start && !tx_bit && !tx_overrun, req,
                {29'd0, tx_start, tx_bit, tx_overrun}, 32'd0);
        end
    endtask

    task automatic tx_seq();
        tx_kick(tx_pat(0));
        for (int k = 0; k < 64; k++) begin
            tx_packet(tx_pat(k), -1, k < 63, tx_pat(k + 1));
        end
        tx_idle(3, "R7 idle after stream");
        for (int p = 0; p < 31; p++) begin
            tx_kick(tx_pat(100 + p));
            tx_packet(tx_pat(100 + p), p, 1'b0, 32'd0);
            tx_idle(2, "R6 refused capture starts nothing");
        end
    endtask

    task automatic rx_packet(input logic [31:0] lanes, input string req);
        logic [31:0] pkt;
        pkt = to_pkt(lanes);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk(!wr_valid, "R8 no early valid", 32'(wr_valid), 32'd0);
            rx_start = (i == 0);
            rx_bit   = pkt[31-i];
        end
        @(negedge clk);
        chk(wr_valid, req, 32'(wr_valid), 32'd1);
        chk(wr_lane_data == lanes, req, wr_lane_data, lanes);
        rx_start = 1'b0;
        rx_bit   = 1'b1;
        for (int g = 0; g < 2; g++) begin
            @(negedge clk);
            chk(!wr_valid, "R8 single valid", 32'(wr_valid), 32'd0);
            chk(wr_lane_data == lanes, "R9 hold, stray bits ignored", wr_lane_data, lanes);
            rx_bit = ~rx_bit;
        end
    endtask

    task automatic rx_abort(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk(!wr_valid, "R10 partial gives no valid", 32'(wr_valid), 32'd0);
            rx_start = (i == 0);
            rx_bit   = i[0];
        end
    endtask

    task automatic rx_seq();
        for (int k = 0; k < 96; k++) begin
            if (k % 7 == 3) begin
                rx_abort(k % 31 + 1);
                rx_packet(rx_pat(k), "R10 restart data");
            end else begin
                rx_packet(rx_pat(k), "R8 R11 write lanes");
            end
        end
    endtask

    initial begin
        rst = 1'b1;
        cyc_en = 1'b0;
        rd_lane_data = 32'hFFFF_FFFF;
        rx_bit = 1'b1;
        rx_start = 1'b0;
        repeat (3) @(negedge clk);
        chk({tx_bit, tx_start, tx_overrun, wr_valid} == 4'b0, "R1 outputs in reset",
            {28'd0, tx_bit, tx_start, tx_overrun, wr_valid}, 32'd0);
        chk(wr_lane_data == 32'd0, "R1 write lanes in reset", wr_lane_data, 32'd0);
        rst = 1'b0;
        rx_bit = 1'b0;
        @(negedge clk);
        chk({tx_bit, tx_start, tx_overrun, wr_valid} == 4'b0, "R1 R7 after reset",
            {28'd0, tx_bit, tx_start, tx_overrun, wr_valid}, 32'd0);
        fork
            tx_seq();
            rx_seq();
        join
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule